// File: doc/BRIEF.md
# Transactional Conflict and Age Arbiter

This block tracks the transactional life of a small fixed set of hardware threads. Each thread has a transaction state, an age and a wait queue. Begin, end and log-overflow events arrive per thread. The memory system reports conflicts: each report names the thread that is asking for a location and the thread that currently owns it. When two running transactions collide, the older one wins. The loser is aborted, starts its cleanup, and is parked on the winner's wait queue. A running thread that meets an owner which is still cleaning up joins that owner's queue.

A thread's age is loaded from a free-running global clock when the thread is created, and it advances by one on every commit. The undo log and the old-value restoration datapath sit outside this block. The only trace of them here is a cleanup-start pulse going out and a cleanup-done strobe coming back. When an owner's cleanup-done arrives, the block pulses wake for every thread queued on that owner in the same cycle and then empties the queue. Suspend is high for any thread that waits on at least one queue.

Top module: `tx_age_arbiter`

## Requirements
- R1: After reset every thread is idle (state code 0) with age 0, and error, suspend, wake, abort-command and cleanup-start outputs are all low. State codes are 2 bits per thread at bits [2t+1:2t]: 0 idle, 1 pending, 2 aborted, 3 committed.
- R2: An idle thread with create high loads its age from `gclock`. An idle thread with begin high becomes pending on the next cycle and its error flag clears. Create and begin in any other state are ignored.
- R3: A pending thread with end high, and with no abort cause in that cycle, is committed on the next cycle. Its age is then one greater, wrapping at the age width, and cleanup-start pulses for that one cycle.
- R4: A conflict between two pending threads goes to the one with the smaller age, or to the lower thread ID when the ages are equal. On the next cycle the loser is aborted and pulses both abort-command and cleanup-start.
- R5: The loser of R4 is placed on the winner's queue. Its suspend rises on the next cycle and stays high until the winner finishes cleanup.
- R6: A conflict whose requester is pending and whose owner is aborted or committed puts the requester on the owner's queue and suspends it. The requester's state does not change.
- R7: A conflict report is ignored in any of these cases: the requester is not pending, requester and owner are the same thread, the owner is idle, or the owner has cleanup-done high in that same cycle.
- R8: An aborted or committed thread with cleanup-done high becomes idle on the next cycle. Wake is high in that same cycle for every thread queued on it, and the queue is empty from the next cycle on.
- R9: A pending thread with log-full high is aborted on the next cycle with its error flag set and abort-command and cleanup-start pulsed. The flag stays set until the thread's next begin. Any abort cause takes priority over end.
- R10: Cleanup-done on an idle or pending thread has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclock | input | AGE_W | Global clock value sampled at thread creation |
| create | input | N_THR | Per-thread creation event |
| tx_begin | input | N_THR | Per-thread transaction begin |
| tx_end | input | N_THR | Per-thread transaction end |
| log_full | input | N_THR | Per-thread undo-log overflow |
| cf_valid | input | 1 | A conflict report is present |
| cf_req | input | TID_W | Requesting thread of the conflict |
| cf_own | input | TID_W | Owning thread of the contested location |
| clean_done | input | N_THR | Per-thread cleanup finished |
| state_o | output | 2*N_THR | Packed per-thread state codes |
| age_o | output | N_THR*AGE_W | Packed per-thread ages |
| err_o | output | N_THR | Per-thread error-handler flag |
| suspend_o | output | N_THR | Thread is waiting on some queue |
| wake_o | output | N_THR | Thread released this cycle |
| abort_cmd_o | output | N_THR | One-cycle abort command |
| clean_start_o | output | N_THR | One-cycle cleanup start |

## Verification
Some properties are checked by assertions on every cycle. No conflict aborts more than one thread, and an aborted loser is never older than its winner. Ages step by exactly one on a commit. Command pulses coincide with the matching state. A queue is empty after its owner finishes, and a suspended thread that is not woken stays suspended.

Other behaviour can only be shown by the bench's scenarios. These are the equal-age tie-break, the cases where a conflict is ignored, wake firing for several threads at once, a thread staying suspended while it waits on a second queue, the error flag lasting until the next begin, and age wrap-around.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PEND = 2'd1,
    TX_ABRT = 2'd2,
    TX_CMIT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/tx_thread_slot.sv
module tx_thread_slot
  import tx_arb_pkg::*;
#(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AGE_W-1:0] gclock,
  input  logic             create,
  input  logic             tx_begin,
  input  logic             tx_end,
  input  logic             log_full,
  input  logic             lost,
  input  logic             clean_done,
  output logic [1:0]       st_o,
  output logic [AGE_W-1:0] age_o,
  output logic             err_o,
  output logic             abort_o,
  output logic             cstart_o
);
  tx_state_e        st_q, st_n;
  logic [AGE_W-1:0] age_q, age_n;
  logic             err_q, err_n, ab_q, ab_n, cs_q, cs_n;

  always_comb begin
    st_n  = st_q;
    age_n = age_q;
    err_n = err_q;
    ab_n  = 1'b0;
    cs_n  = 1'b0;
    case (st_q)
      TX_IDLE: begin
        if (create) age_n = gclock;
        if (tx_begin) begin
          st_n  = TX_PEND;
          err_n = 1'b0;
        end
      end
      TX_PEND: begin
        if (lost || log_full) begin
          st_n  = TX_ABRT;
          ab_n  = 1'b1;
          cs_n  = 1'b1;
          err_n = log_full;
        end else if (tx_end) begin
          st_n  = TX_CMIT;
          age_n = age_q + AGE_W'(1);
          cs_n  = 1'b1;
        end
      end
      default: begin
        if (clean_done) st_n = TX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      age_q <= '0;
      err_q <= 1'b0;
      ab_q  <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      age_q <= age_n;
      err_q <= err_n;
      ab_q  <= ab_n;
      cs_q  <= cs_n;
    end
  end

  assign st_o     = st_q;
  assign age_o    = age_q;
  assign err_o    = err_q;
  assign abort_o  = ab_q;
  assign cstart_o = cs_q;

  AST_AGE_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_PEND && tx_end && !lost && !log_full) |=> (age_q == $past(age_q) + AGE_W'(1))); // R3
  AST_ABORT_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ab_q |-> (st_q == TX_ABRT)); // R4
  AST_CSTART_IN_CLEANUP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> (st_q == TX_ABRT || st_q == TX_CMIT)); // R3
  AST_ERR_RISES_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (st_q == TX_ABRT)); // R9
endmodule

// File: rtl/tx_conflict_judge.sv
module tx_conflict_judge
  import tx_arb_pkg::*;
#(
  parameter int N_THR = 4,
  parameter int AGE_W = 8,
  parameter int TID_W = $clog2(N_THR)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_THR-1:0][1:0]       st,
  input  logic [N_THR-1:0][AGE_W-1:0] age,
  input  logic                        cf_valid,
  input  logic [TID_W-1:0]            cf_req,
  input  logic [TID_W-1:0]            cf_own,
  input  logic [N_THR-1:0]            clean_done,
  output logic [N_THR-1:0]            lose,
  output logic                        enq_v,
  output logic [TID_W-1:0]            enq_own,
  output logic [TID_W-1:0]            enq_wait
);
  logic usable, req_older, own_cleaning;

  always_comb begin
    lose         = '0;
    enq_v        = 1'b0;
    enq_own      = cf_own;
    enq_wait     = cf_req;
    usable       = cf_valid && (cf_req != cf_own) && (st[cf_req] == TX_PEND)
                   && !clean_done[cf_own];
    own_cleaning = (st[cf_own] == TX_ABRT) || (st[cf_own] == TX_CMIT);
    req_older    = (age[cf_req] < age[cf_own]) ||
                   ((age[cf_req] == age[cf_own]) && (cf_req < cf_own));
    if (usable && st[cf_own] == TX_PEND) begin
      enq_v = 1'b1;
      if (req_older) begin
        lose[cf_own] = 1'b1;
        enq_own      = cf_req;
        enq_wait     = cf_own;
      end else begin
        lose[cf_req] = 1'b1;
      end
    end else if (usable && own_cleaning) begin
      enq_v = 1'b1;
    end
  end

  AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lose)); // R4
  AST_OLDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_v && lose != '0) |-> ((age[enq_wait] > age[enq_own]) ||
      (age[enq_wait] == age[enq_own] && enq_wait > enq_own))); // R4
  AST_NO_SELF_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    enq_v |-> (enq_own != enq_wait)); // R7
endmodule

// File: rtl/tx_wait_matrix.sv
module tx_wait_matrix #(
  parameter int N_THR = 4,
  parameter int TID_W = $clog2(N_THR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_THR-1:0] fin,
  input  logic             enq_v,
  input  logic [TID_W-1:0] enq_own,
  input  logic [TID_W-1:0] enq_wait,
  output logic [N_THR-1:0] wake_o,
  output logic [N_THR-1:0] suspend_o
);
  logic [N_THR-1:0][N_THR-1:0] q_q, q_n;

  always_comb begin
    q_n       = q_q;
    wake_o    = '0;
    suspend_o = '0;
    for (int o = 0; o < N_THR; o++) begin
      suspend_o = suspend_o | q_q[o];
      if (fin[o]) begin
        wake_o = wake_o | q_q[o];
        q_n[o] = '0;
      end
    end
    if (enq_v) q_n[enq_own][enq_wait] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_n;
  end

  for (genvar o = 0; o < N_THR; o++) begin : g_chk
    AST_QUEUE_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
      fin[o] |=> (q_q[o] == '0)); // R8
  end
endmodule

// File: rtl/tx_age_arbiter.sv
module tx_age_arbiter
  import tx_arb_pkg::*;
#(
  parameter int N_THR = 4,
  parameter int AGE_W = 8,
  parameter int TID_W = $clog2(N_THR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AGE_W-1:0]         gclock,
  input  logic [N_THR-1:0]         create,
  input  logic [N_THR-1:0]         tx_begin,
  input  logic [N_THR-1:0]         tx_end,
  input  logic [N_THR-1:0]         log_full,
  input  logic                     cf_valid,
  input  logic [TID_W-1:0]         cf_req,
  input  logic [TID_W-1:0]         cf_own,
  input  logic [N_THR-1:0]         clean_done,
  output logic [2*N_THR-1:0]       state_o,
  output logic [N_THR*AGE_W-1:0]   age_o,
  output logic [N_THR-1:0]         err_o,
  output logic [N_THR-1:0]         suspend_o,
  output logic [N_THR-1:0]         wake_o,
  output logic [N_THR-1:0]         abort_cmd_o,
  output logic [N_THR-1:0]         clean_start_o
);
  logic [N_THR-1:0][1:0]       st_w;
  logic [N_THR-1:0][AGE_W-1:0] age_w;
  logic [N_THR-1:0]            lose, fin;
  logic                        enq_v;
  logic [TID_W-1:0]            enq_own, enq_wait;

  for (genvar t = 0; t < N_THR; t++) begin : g_slot
    tx_thread_slot #(.AGE_W(AGE_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .gclock(gclock),
      .create(create[t]), .tx_begin(tx_begin[t]), .tx_end(tx_end[t]),
      .log_full(log_full[t]), .lost(lose[t]), .clean_done(clean_done[t]),
      .st_o(st_w[t]), .age_o(age_w[t]), .err_o(err_o[t]),
      .abort_o(abort_cmd_o[t]), .cstart_o(clean_start_o[t])
    );
    assign fin[t] = clean_done[t] && (st_w[t] == TX_ABRT || st_w[t] == TX_CMIT);
  end

  tx_conflict_judge #(.N_THR(N_THR), .AGE_W(AGE_W), .TID_W(TID_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .st(st_w), .age(age_w),
    .cf_valid(cf_valid), .cf_req(cf_req), .cf_own(cf_own),
    .clean_done(clean_done), .lose(lose), .enq_v(enq_v),
    .enq_own(enq_own), .enq_wait(enq_wait)
  );

  tx_wait_matrix #(.N_THR(N_THR), .TID_W(TID_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .fin(fin), .enq_v(enq_v),
    .enq_own(enq_own), .enq_wait(enq_wait),
    .wake_o(wake_o), .suspend_o(suspend_o)
  );

  assign state_o = st_w;
  assign age_o   = age_w;

  for (genvar t = 0; t < N_THR; t++) begin : g_sus
    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend_o[t] && !wake_o[t]) |=> suspend_o[t]); // R5
  end
endmodule

// File: tb/sim_tx_age_arbiter.sv
`timescale 1ns/1ps
module sim_tx_age_arbiter;
  localparam int N = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] gclock;
  logic [N-1:0] create, tx_begin, tx_end, log_full, clean_done;
  logic cf_valid;
  logic [1:0] cf_req, cf_own;
  logic [2*N-1:0] state_o;
  logic [N*AW-1:0] age_o;
  logic [N-1:0] err_o, suspend_o, wake_o, abort_cmd_o, clean_start_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_st [N];
  int m_age [N];
  bit m_err [N];
  bit m_ab [N];
  bit m_cs [N];
  bit m_q [N][N];

  always #5 clk = ~clk;

  tx_age_arbiter #(.N_THR(N), .AGE_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .gclock(gclock), .create(create),
    .tx_begin(tx_begin), .tx_end(tx_end), .log_full(log_full),
    .cf_valid(cf_valid), .cf_req(cf_req), .cf_own(cf_own),
    .clean_done(clean_done), .state_o(state_o), .age_o(age_o),
    .err_o(err_o), .suspend_o(suspend_o), .wake_o(wake_o),
    .abort_cmd_o(abort_cmd_o), .clean_start_o(clean_start_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clr_in();
    create = '0; tx_begin = '0; tx_end = '0; log_full = '0;
    clean_done = '0; cf_valid = 1'b0; cf_req = '0; cf_own = '0;
  endtask

  task automatic model_reset();
    for (int t = 0; t < N; t++) begin
      m_st[t] = 0; m_age[t] = 0; m_err[t] = 0; m_ab[t] = 0; m_cs[t] = 0;
      for (int w = 0; w < N; w++) m_q[t][w] = 0;
    end
  endtask

  task automatic compare();
    bit ew [N];
    bit es [N];
    for (int t = 0; t < N; t++) begin ew[t] = 0; es[t] = 0; end
    for (int o = 0; o < N; o++)
      for (int w = 0; w < N; w++) begin
        if (m_q[o][w]) es[w] = 1;
        if (m_q[o][w] && clean_done[o] && m_st[o] >= 2) ew[w] = 1;
      end
    for (int t = 0; t < N; t++) begin
      chk("R4", $sformatf("state[%0d]", t), int'(state_o[2*t +: 2]), m_st[t]);
      chk("R3", $sformatf("age[%0d]", t), int'(age_o[t*AW +: AW]), m_age[t]);
      chk("R9", $sformatf("err[%0d]", t), int'(err_o[t]), int'(m_err[t]));
      chk("R5", $sformatf("suspend[%0d]", t), int'(suspend_o[t]), int'(es[t]));
      chk("R8", $sformatf("wake[%0d]", t), int'(wake_o[t]), int'(ew[t]));
      chk("R4", $sformatf("abort_cmd[%0d]", t), int'(abort_cmd_o[t]), int'(m_ab[t]));
      chk("R3", $sformatf("clean_start[%0d]", t), int'(clean_start_o[t]), int'(m_cs[t]));
    end
  endtask

  // Behavioural reference: applies the requirement rules to the sampled inputs
  task automatic model_step();
    bit lost [N];
    bit fin [N];
    int r, o, win, los;
    bit older;
    for (int t = 0; t < N; t++) begin
      lost[t] = 0;
      fin[t] = clean_done[t] && m_st[t] >= 2;
    end
    for (int x = 0; x < N; x++)
      if (fin[x]) for (int w = 0; w < N; w++) m_q[x][w] = 0;
    r = int'(cf_req); o = int'(cf_own);
    if (cf_valid && r != o && m_st[r] == 1 && !clean_done[o]) begin
      if (m_st[o] == 1) begin
        older = (m_age[r] < m_age[o]) || (m_age[r] == m_age[o] && r < o);
        win = older ? r : o;
        los = older ? o : r;
        lost[los] = 1;
        m_q[win][los] = 1;
      end else if (m_st[o] >= 2) begin
        m_q[o][r] = 1;
      end
    end
    for (int t = 0; t < N; t++) begin
      m_ab[t] = 0; m_cs[t] = 0;
      case (m_st[t])
        0: begin
          if (create[t]) m_age[t] = int'(gclock);
          if (tx_begin[t]) begin m_st[t] = 1; m_err[t] = 0; end
        end
        1: begin
          if (lost[t] || log_full[t]) begin
            m_st[t] = 2; m_ab[t] = 1; m_cs[t] = 1; m_err[t] = log_full[t];
          end else if (tx_end[t]) begin
            m_st[t] = 3; m_age[t] = (m_age[t] + 1) % 256; m_cs[t] = 1;
          end
        end
        default: if (clean_done[t]) m_st[t] = 0;
      endcase
    end
  endtask

  task automatic cyc();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    clr_in();
  endtask

  task automatic conflict(int r, int o);
    cf_valid = 1'b1; cf_req = 2'(r); cf_own = 2'(o);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clr_in();
    gclock = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "state after reset", int'(state_o), 0);
    chk("R1", "suspend after reset", int'(suspend_o), 0);
    chk("R1", "ages after reset", int'(age_o != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc();

    // R2: creation loads ages
    gclock = 8'd10; create = 4'b0001; cyc();
    gclock = 8'd5;  create = 4'b0110; cyc();
    gclock = 8'd200; create = 4'b1000; cyc();
    tx_begin = 4'b1111; cyc();
    #1; chk("R2", "all pending", int'(state_o), 8'b01010101);
    gclock = 8'd77; create = 4'b0001; cyc();
    #1; chk("R2", "create ignored when pending", int'(age_o[7:0]), 10);

    // R4: older t1 beats t0; equal ages: t1 beats t2 on ID
    conflict(0, 1); cyc();
    #1; chk("R4", "t0 aborted", int'(state_o[1:0]), 2);
    chk("R5", "t0 suspended", int'(suspend_o[0]), 1);
    conflict(2, 1); cyc();
    #1; chk("R4", "tie loser t2", int'(state_o[5:4]), 2);

    // R6: t3 meets aborted owner t0
    conflict(3, 0); cyc();
    #1; chk("R6", "t3 still pending", int'(state_o[7:6]), 1);
    chk("R6", "t3 suspended", int'(suspend_o[3]), 1);

    // R7: requester not pending, self conflict
    conflict(0, 3); cyc();
    conflict(3, 3); cyc();
    #1; chk("R7", "t3 unchanged", int'(state_o[7:6]), 1);

    // R10: cleanup-done on pending owner ignored
    clean_done = 4'b0010; cyc();
    #1; chk("R10", "t1 still pending", int'(state_o[3:2]), 1);

    // R8: t0 finishes, wakes t3; t0 stays suspended on t1
    clean_done = 4'b0001; #1;
    chk("R8", "wake t3", int'(wake_o), 4'b1000);
    cyc();
    #1; chk("R8", "t0 still waits on t1", int'(suspend_o), 4'b0101);

    // R7: owner finishing in the same cycle
    conflict(3, 2); clean_done = 4'b0100; cyc();
    #1; chk("R7", "t3 not queued", int'(suspend_o[3]), 0);

    // R3: t1 commits, then its cleanup wakes t0 and t2 together
    tx_end = 4'b0010; cyc();
    #1; chk("R3", "t1 committed age", int'(age_o[15:8]), 6);
    clean_done = 4'b0010; #1;
    chk("R8", "multi wake", int'(wake_o), 4'b0101);
    cyc();
    #1; chk("R8", "nobody suspended", int'(suspend_o), 0);

    // R9: overflow abort, flag lasts until next begin; overflow beats end
    log_full = 4'b1000; tx_end = 4'b1000; cyc();
    #1; chk("R9", "err set", int'(err_o[3]), 1);
    clean_done = 4'b1000; cyc();
    #1; chk("R9", "err held in idle", int'(err_o[3]), 1);
    tx_begin = 4'b1000; cyc();
    #1; chk("R9", "err cleared", int'(err_o[3]), 0);

    // R3: age wrap
    tx_end = 4'b1000; cyc();
    clean_done = 4'b1000; cyc();
    gclock = 8'd255; create = 4'b1000; tx_begin = 4'b1000; cyc();
    tx_end = 4'b1000; cyc();
    #1; chk("R3", "age wraps", int'(age_o[31:24]), 0);
    clean_done = 4'b1000; cyc();

    // Mixed random traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      gclock = 8'($urandom);
      create = 4'($urandom) & 4'($urandom);
      tx_begin = 4'($urandom) & 4'($urandom);
      tx_end = 4'($urandom) & 4'($urandom) & 4'($urandom);
      log_full = 4'($urandom) & 4'($urandom) & 4'($urandom) & 4'($urandom);
      clean_done = 4'($urandom) & 4'($urandom);
      cf_valid = 1'($urandom);
      cf_req = 2'($urandom);
      cf_own = 2'($urandom);
      cyc();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule